// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block hands incoming frames to software through a circular list of receive descriptors. The descriptors sit in a small internal table. Each entry is one 32-bit word: a 16-bit status half in bits 31:16 and a 16-bit length half in bits 15:0. Software fills the table through a simple write/read port and marks each entry it gives to the engine as empty.

A frame arrives as a byte stream with start and end markers, and its error indications come on the last byte. When a frame starts, the engine looks at the descriptor at its current position. If that descriptor is empty, the engine counts the bytes. At the end of the frame it writes the count and the error bits, hands the entry back by clearing the empty flag, sets the full-frame event and moves to the next entry. If the descriptor is not empty, the engine drops the frame and waits until software pokes the activate input.

The current position is an offset from a configurable ring base. The ring closes at an entry whose wrap bit is set, or after a configurable number of entries, whichever comes first. Frame data is not stored; only its length is recorded.

Control sits in one state machine with five states:
- `ST_IDLE`: waiting for a frame start. A start on an empty descriptor goes to `ST_RECV`, or straight to `ST_CLOSE` for a one-byte frame. A start on an owned descriptor goes to `ST_DROP`, or to `ST_STALL` for a one-byte frame.
- `ST_RECV`: counting bytes. The end marker goes to `ST_CLOSE`.
- `ST_CLOSE`: one cycle that writes the descriptor back, raises the event, advances the position and returns to `ST_IDLE`.
- `ST_DROP`: discarding a frame. Its end marker goes to `ST_STALL`.
- `ST_STALL`: parked. Activate returns to `ST_IDLE`. A new frame start goes to `ST_DROP`, or stays in `ST_STALL` for a one-byte frame.

A soft reset from any state returns the machine to `ST_IDLE` at offset zero.

Top module: `rxbd_ring_engine`

## Requirements
- R1: After reset, every descriptor word reads 0, the event register reads 0 and `irq` is low.
- R2: A software write stores a 32-bit descriptor word, and a read returns the addressed word one clock after the address is presented.
- R3: Closing a frame clears status bit 15 (empty, word bit 31), sets status bit 11 (last, word bit 27), keeps status bits 14:12 (wrap is bit 13) and clears bits 10:6. It writes the frame's byte count, FCS included, into the length half.
- R4: The error bits in the closed status are: bit 0 late collision, bit 1 overrun, bit 2 CRC, bit 3 too short (count below MIN_BYTES), bit 4 non-octet alignment, and bit 5 too long (count above MAX_BYTES). The byte count saturates at BUF_BYTES. A short or errored frame still closes its descriptor.
- R5: After a close, the position returns to the ring base when the closed entry has its wrap bit set or is entry `cfg_len`-1 of the ring. Otherwise it moves to the next consecutive entry.
- R6: A frame that starts on a descriptor without the empty flag is dropped and leaves the table untouched. The engine then stalls, and it also drops later frames, even onto a descriptor that software has since made empty.
- R7: A pulse on `rx_kick` while stalled makes the engine look at the current descriptor again for the next frame.
- R8: Each close sets event bit 25. Writing a one to bit 25 through the clear port clears it, and a set in the same cycle wins. Writing ones to other bits has no effect. `irq` is high exactly when the event bit is set and mask bit 25 is set.
- R9: `soft_rst` returns the position to the ring base and leaves any stall.
- R10: A dropped frame raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Return the ring position to the base and go idle |
| cfg_base | input | IDX_W | Table index of the ring's first entry |
| cfg_len | input | IDX_W+1 | Maximum number of entries in the ring |
| sw_we | input | 1 | Software descriptor write strobe |
| sw_addr | input | IDX_W | Software descriptor index |
| sw_wdata | input | 32 | Software write word {status, length} |
| sw_rdata | output | 32 | Registered read of the word at `sw_addr` |
| rx_valid | input | 1 | One frame byte this cycle |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_crc_err | input | 1 | CRC error, valid with `rx_eof` |
| rx_align_err | input | 1 | Non-octet alignment, valid with `rx_eof` |
| rx_ovr_err | input | 1 | Receive overrun, valid with `rx_eof` |
| rx_col_err | input | 1 | Late collision, valid with `rx_eof` |
| rx_kick | input | 1 | Activate pulse: restart a stalled engine |
| evt_clr_we | input | 1 | Event clear strobe |
| evt_clr_data | input | 32 | Ones clear the matching event bits |
| evt_mask | input | 32 | Interrupt mask over the event register |
| evt_status | output | 32 | Event register (bit 25 = frame received) |
| irq | output | 1 | Masked event interrupt |

## Verification
The bench builds the engine with an 8-entry table and the frame limits cut to MIN_BYTES=8, MAX_BYTES=30 and BUF_BYTES=32. With these values, short frames, long frames and length saturation each take only tens of cycles.

The small table lets the ring run at base 2. One pass closes the ring by a wrap bit, and a later pass closes it by the length limit. Both wrap-around paths, the stall-then-activate sequence and the soft-reset return are covered within a short run.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_CLOSE,
        ST_DROP,
        ST_STALL
    } rx_state_e;

    // Status half-word bit positions
    localparam int ST_EMPTY_BIT = 15;
    localparam int ST_WRAP_BIT  = 13;
    localparam int ST_LAST_BIT  = 11;

    // Error bit positions in the status half-word
    localparam int ERR_COL_BIT   = 0;
    localparam int ERR_OVR_BIT   = 1;
    localparam int ERR_CRC_BIT   = 2;
    localparam int ERR_SHORT_BIT = 3;
    localparam int ERR_ALIGN_BIT = 4;
    localparam int ERR_LONG_BIT  = 5;
    localparam int ERR_W         = 6;

    // Status bits that survive a close untouched
    localparam logic [15:0] ST_KEEP_MASK = 16'h7000;

    // Event register: frame received
    localparam int EVT_RXF_BIT = 25;

endpackage

// File: rtl/rxbd_store.sv
module rxbd_store #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_addr,
    input  logic [31:0]      sw_wdata,
    output logic [31:0]      sw_rdata,
    input  logic             eng_we,
    input  logic [IDX_W-1:0] eng_idx,
    input  logic [31:0]      eng_wdata,
    output logic [15:0]      eng_status
);
    localparam int DEPTH = 1 << IDX_W;

    logic [31:0] tbl [DEPTH];

    // Engine write wins over a software write to the same entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (eng_we && eng_idx == IDX_W'(i))
                    tbl[i] <= eng_wdata;
                else if (sw_we && sw_addr == IDX_W'(i))
                    tbl[i] <= sw_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sw_rdata <= '0;
        else        sw_rdata <= tbl[sw_addr];
    end

    assign eng_status = tbl[eng_idx][31:16];

endmodule

// File: rtl/rxbd_len_track.sv
module rxbd_len_track
    import rxbd_pkg::*;
#(
    parameter int BUF_BYTES = 1520,
    parameter int MIN_BYTES = 64,
    parameter int MAX_BYTES = 1518,
    parameter int LEN_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             beat,
    input  logic             capture,
    input  logic             crc_err,
    input  logic             align_err,
    input  logic             ovr_err,
    input  logic             col_err,
    output logic [LEN_W-1:0] byte_cnt,
    output logic [ERR_W-1:0] err_flags
);
    logic crc_q, align_q, ovr_q, col_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_cnt <= '0;
        end else if (start) begin
            byte_cnt <= LEN_W'(1);
        end else if (beat && byte_cnt < LEN_W'(BUF_BYTES)) begin
            byte_cnt <= byte_cnt + LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {crc_q, align_q, ovr_q, col_q} <= '0;
        end else if (capture) begin
            {crc_q, align_q, ovr_q, col_q} <= {crc_err, align_err, ovr_err, col_err};
        end else if (start) begin
            {crc_q, align_q, ovr_q, col_q} <= '0;
        end
    end

    always_comb begin
        err_flags                = '0;
        err_flags[ERR_COL_BIT]   = col_q;
        err_flags[ERR_OVR_BIT]   = ovr_q;
        err_flags[ERR_CRC_BIT]   = crc_q;
        err_flags[ERR_ALIGN_BIT] = align_q;
        err_flags[ERR_SHORT_BIT] = byte_cnt < LEN_W'(MIN_BYTES);
        err_flags[ERR_LONG_BIT]  = byte_cnt > LEN_W'(MAX_BYTES);
    end

endmodule

// File: rtl/rxbd_fsm.sv
module rxbd_fsm
    import rxbd_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             rx_kick,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [IDX_W:0]   cfg_len,
    input  logic             cur_empty,
    input  logic             cur_wrap,
    output logic [IDX_W-1:0] ptr_off,
    output logic             trk_start,
    output logic             trk_beat,
    output logic             trk_capture,
    output logic             close,
    output logic             stalled
);
    rx_state_e state, state_nx;
    logic      ring_last;
    logic      byte_sof, byte_eof;

    assign byte_sof  = rx_valid && rx_sof;
    assign byte_eof  = rx_valid && rx_eof;
    assign ring_last = (ptr_off == IDX_W'(cfg_len - (IDX_W+1)'(1)));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (byte_sof) begin
                    if (cur_empty) state_nx = rx_eof ? ST_CLOSE : ST_RECV;
                    else           state_nx = rx_eof ? ST_STALL : ST_DROP;
                end
            end
            ST_RECV:  if (byte_eof) state_nx = ST_CLOSE;
            ST_CLOSE: state_nx = ST_IDLE;
            ST_DROP:  if (byte_eof) state_nx = ST_STALL;
            ST_STALL: begin
                if (rx_kick)                  state_nx = ST_IDLE;
                else if (byte_sof && !rx_eof) state_nx = ST_DROP;
            end
            default:  state_nx = ST_IDLE;
        endcase
        if (soft_rst) state_nx = ST_IDLE;
    end

    // Outputs
    always_comb begin
        trk_start   = 1'b0;
        trk_beat    = 1'b0;
        trk_capture = 1'b0;
        close       = 1'b0;
        stalled     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                trk_start   = byte_sof && cur_empty;
                trk_capture = byte_sof && cur_empty && rx_eof;
            end
            ST_RECV: begin
                trk_beat    = rx_valid;
                trk_capture = byte_eof;
            end
            ST_CLOSE: close   = !soft_rst;
            ST_DROP:  ;
            ST_STALL: stalled = 1'b1;
            default:  ;
        endcase
    end

    // Ring position as offset from the base
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_off <= '0;
        end else if (soft_rst) begin
            ptr_off <= '0;
        end else if (close) begin
            ptr_off <= (cur_wrap || ring_last) ? '0 : ptr_off + IDX_W'(1);
        end
    end

endmodule

// File: rtl/rxbd_ring_engine.sv
module rxbd_ring_engine
    import rxbd_pkg::*;
#(
    parameter int IDX_W     = 4,
    parameter int BUF_BYTES = 1520,
    parameter int MIN_BYTES = 64,
    parameter int MAX_BYTES = 1518
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic [IDX_W-1:0] cfg_base,
    input  logic [IDX_W:0]   cfg_len,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_addr,
    input  logic [31:0]      sw_wdata,
    output logic [31:0]      sw_rdata,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic             rx_crc_err,
    input  logic             rx_align_err,
    input  logic             rx_ovr_err,
    input  logic             rx_col_err,
    input  logic             rx_kick,
    input  logic             evt_clr_we,
    input  logic [31:0]      evt_clr_data,
    input  logic [31:0]      evt_mask,
    output logic [31:0]      evt_status,
    output logic             irq
);
    localparam int LEN_W = $clog2(BUF_BYTES + 1);

    logic [IDX_W-1:0] ptr_off, cur_idx;
    logic [15:0]      cur_status, new_status;
    logic [LEN_W-1:0] byte_cnt;
    logic [ERR_W-1:0] err_flags;
    logic             trk_start, trk_beat, trk_capture;
    logic             eng_we, stalled, evt_rxf;
    logic [31:0]      eng_wdata;

    assign cur_idx = cfg_base + ptr_off;

    rxbd_store #(.IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_we      (sw_we),
        .sw_addr    (sw_addr),
        .sw_wdata   (sw_wdata),
        .sw_rdata   (sw_rdata),
        .eng_we     (eng_we),
        .eng_idx    (cur_idx),
        .eng_wdata  (eng_wdata),
        .eng_status (cur_status)
    );

    rxbd_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .rx_kick     (rx_kick),
        .rx_valid    (rx_valid),
        .rx_sof      (rx_sof),
        .rx_eof      (rx_eof),
        .cfg_len     (cfg_len),
        .cur_empty   (cur_status[ST_EMPTY_BIT]),
        .cur_wrap    (cur_status[ST_WRAP_BIT]),
        .ptr_off     (ptr_off),
        .trk_start   (trk_start),
        .trk_beat    (trk_beat),
        .trk_capture (trk_capture),
        .close       (eng_we),
        .stalled     (stalled)
    );

    rxbd_len_track #(
        .BUF_BYTES (BUF_BYTES),
        .MIN_BYTES (MIN_BYTES),
        .MAX_BYTES (MAX_BYTES),
        .LEN_W     (LEN_W)
    ) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (trk_start),
        .beat      (trk_beat),
        .capture   (trk_capture),
        .crc_err   (rx_crc_err),
        .align_err (rx_align_err),
        .ovr_err   (rx_ovr_err),
        .col_err   (rx_col_err),
        .byte_cnt  (byte_cnt),
        .err_flags (err_flags)
    );

    // Descriptor write-back word
    always_comb begin
        new_status                    = cur_status & ST_KEEP_MASK;
        new_status[ST_LAST_BIT]       = 1'b1;
        new_status[ERR_W-1:0]         = err_flags;
        eng_wdata                     = {new_status, 16'(byte_cnt)};
    end

    // Event register, set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            evt_rxf <= 1'b0;
        else if (eng_we)
            evt_rxf <= 1'b1;
        else if (evt_clr_we && (evt_clr_data & evt_status) != '0)
            evt_rxf <= 1'b0;
    end

    always_comb begin
        evt_status              = '0;
        evt_status[EVT_RXF_BIT] = evt_rxf;
    end

    assign irq = |(evt_status & evt_mask);

endmodule

// File: rtl/rxbd_ring_chk.sv
module rxbd_ring_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             rx_kick,
    input logic             stalled,
    input logic             eng_we,
    input logic             wr_empty,
    input logic             wr_last,
    input logic             cur_wrap,
    input logic [IDX_W-1:0] ptr_off,
    input logic [31:0]      evt_status
);
    // R3
    close_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> (!wr_empty && wr_last));

    // R8
    rxf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |=> evt_status[25]);

    // R10
    rxf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_status[25]) |-> $past(eng_we));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled && !rx_kick && !soft_rst) |=> !eng_we);

    // R5
    wrap_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_we && cur_wrap && !soft_rst) |=> (ptr_off == '0));

    // R9
    soft_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ptr_off == '0));

    // R8
    evt_only_rxf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_status & ~(32'h1 << 25)) == '0);

endmodule

bind rxbd_ring_engine rxbd_ring_chk #(.IDX_W(IDX_W)) u_rxbd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .rx_kick    (rx_kick),
    .stalled    (stalled),
    .eng_we     (eng_we),
    .wr_empty   (eng_wdata[31]),
    .wr_last    (eng_wdata[27]),
    .cur_wrap   (cur_status[13]),
    .ptr_off    (ptr_off),
    .evt_status (evt_status)
);

// File: tb/test_rxbd_ring_engine.sv
module test_rxbd_ring_engine;
    localparam int IDX_W = 3;
    localparam int DEPTH = 8;
    localparam int BUFB  = 32;
    localparam int MINB  = 8;
    localparam int MAXB  = 30;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             soft_rst = 1'b0;
    logic [IDX_W-1:0] cfg_base = 3'd2;
    logic [IDX_W:0]   cfg_len = 4'd8;
    logic             sw_we = 1'b0;
    logic [IDX_W-1:0] sw_addr = '0;
    logic [31:0]      sw_wdata = '0;
    logic [31:0]      sw_rdata;
    logic             rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic             rx_crc_err = 1'b0, rx_align_err = 1'b0;
    logic             rx_ovr_err = 1'b0, rx_col_err = 1'b0;
    logic             rx_kick = 1'b0;
    logic             evt_clr_we = 1'b0;
    logic [31:0]      evt_clr_data = '0;
    logic [31:0]      evt_mask = '0;
    logic [31:0]      evt_status;
    logic             irq;

    always #2 clk = ~clk;

    rxbd_ring_engine #(
        .IDX_W(IDX_W), .BUF_BYTES(BUFB), .MIN_BYTES(MINB), .MAX_BYTES(MAXB)
    ) i_rxbd_ring_engine (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cfg_base(cfg_base), .cfg_len(cfg_len),
        .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_crc_err(rx_crc_err), .rx_align_err(rx_align_err),
        .rx_ovr_err(rx_ovr_err), .rx_col_err(rx_col_err),
        .rx_kick(rx_kick), .evt_clr_we(evt_clr_we), .evt_clr_data(evt_clr_data),
        .evt_mask(evt_mask), .evt_status(evt_status), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Bench model of the ring
    logic [31:0] mdesc [DEPTH];
    int          exp_off = 0;
    bit          exp_stall = 0;

    // Scoreboard
    int          q_idx [$];
    logic [31:0] q_word [$];
    bit          q_acc [$];
    string       q_tag [$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sw_write(input int idx, input logic [31:0] w);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = IDX_W'(idx); sw_wdata = w;
        @(negedge clk);
        sw_we = 1'b0;
        mdesc[idx] = w;
    endtask

    task automatic sw_read(input int idx, output logic [31:0] w);
        @(negedge clk);
        sw_addr = IDX_W'(idx);
        @(negedge clk);
        w = sw_rdata;
    endtask

    task automatic pulse_kick();
        @(negedge clk); rx_kick = 1'b1;
        @(negedge clk); rx_kick = 1'b0;
        exp_stall = 0;
    endtask

    task automatic pulse_soft();
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        exp_offset_reset();
    endtask

    function automatic void exp_offset_reset();
        exp_off = 0;
        exp_stall = 0;
    endfunction

    // Driver: streams a frame and pushes the expected result
    task automatic send_frame(input int n, input bit crc, input bit aln,
                              input bit ovr, input bit col, input string tag);
        int          idx;
        logic [15:0] st;
        logic [15:0] ln;
        idx = (int'(cfg_base) + exp_off) % DEPTH;
        if (!exp_stall && mdesc[idx][31]) begin
            st = (mdesc[idx][31:16] & 16'h7000) | 16'h0800;
            st[0] = col; st[1] = ovr; st[2] = crc; st[4] = aln;
            st[3] = (n < MINB);
            st[5] = (n > MAXB);
            ln = 16'((n > BUFB) ? BUFB : n);
            if (mdesc[idx][29] || exp_off == int'(cfg_len) - 1) exp_off = 0;
            else exp_off = (exp_off + 1) % DEPTH;
            mdesc[idx] = {st, ln};
            q_acc.push_back(1'b1);
        end else begin
            exp_stall = 1;
            q_acc.push_back(1'b0);
        end
        q_idx.push_back(idx);
        q_word.push_back(mdesc[idx]);
        q_tag.push_back(tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof = (i == 0);
            rx_eof = (i == n - 1);
            rx_crc_err = (i == n - 1) && crc;
            rx_align_err = (i == n - 1) && aln;
            rx_ovr_err = (i == n - 1) && ovr;
            rx_col_err = (i == n - 1) && col;
        end
        @(negedge clk);
        {rx_valid, rx_sof, rx_eof, rx_crc_err, rx_align_err, rx_ovr_err, rx_col_err} = '0;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops the next expected item and compares the design's result
    task automatic monitor_pop();
        int          idx;
        logic [31:0] w, exp_w;
        bit          acc;
        string       tag;
        idx = q_idx.pop_front();
        exp_w = q_word.pop_front();
        acc = q_acc.pop_front();
        tag = q_tag.pop_front();
        sw_read(idx, w);
        check(tag, w, exp_w);
        check({tag, " R8 event"}, evt_status, acc ? (32'h1 << 25) : 32'h0);
        check({tag, " R8 irq"}, {31'h0, irq}, {31'h0, acc && evt_mask[25]});
        @(negedge clk);
        evt_clr_we = 1'b1; evt_clr_data = 32'h1 << 25;
        @(negedge clk);
        evt_clr_we = 1'b0; evt_clr_data = '0;
    endtask

    initial begin
        logic [31:0] w;
        for (int i = 0; i < DEPTH; i++) mdesc[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 event", evt_status, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        sw_read(2, w);
        check("R1 descriptor", w, 32'h0);

        // R2 software port
        sw_write(2, 32'h8000_0000);
        sw_write(3, 32'hD000_0000);
        sw_write(4, 32'hA000_0000);
        sw_read(3, w);
        check("R2 readback", w, 32'hD000_0000);
        evt_mask = 32'h1 << 25;

        send_frame(20, 0, 0, 0, 0, "R3 plain frame");
        monitor_pop();
        send_frame(12, 1, 0, 0, 0, "R3 R4 crc and keep bits");
        monitor_pop();
        send_frame(40, 0, 0, 0, 0, "R4 R5 long saturate wrap");
        monitor_pop();
        send_frame(5, 0, 0, 0, 0, "R6 R10 owned drop");
        monitor_pop();
        sw_write(2, 32'h8000_0000);
        send_frame(9, 0, 0, 0, 0, "R6 stall persists");
        monitor_pop();
        pulse_kick();
        send_frame(5, 0, 1, 1, 1, "R7 R4 after kick");
        monitor_pop();

        // R9 soft reset back to base
        pulse_soft();
        sw_write(2, 32'h8000_0000);
        send_frame(1, 0, 0, 0, 0, "R9 R4 single byte at base");
        monitor_pop();

        // R5 ring closed by length limit
        pulse_soft();
        cfg_len = 4'd2;
        sw_write(2, 32'h8000_0000);
        sw_write(3, 32'h8000_0000);
        sw_write(4, 32'h8000_0000);
        send_frame(10, 0, 0, 0, 0, "R5 len ring first");
        monitor_pop();
        send_frame(10, 0, 0, 0, 0, "R5 len ring second");
        monitor_pop();
        sw_write(2, 32'h8000_0000);
        send_frame(10, 0, 0, 0, 0, "R5 len ring back to base");
        monitor_pop();
        sw_read(4, w);
        check("R5 entry past limit untouched", w, 32'h8000_0000);

        // R8 mask and write-one-to-clear
        sw_write(3, 32'h8000_0000);
        evt_mask = 32'h0;
        send_frame(10, 0, 0, 0, 0, "R8 masked");
        check("R8 masked irq low", {31'h0, irq}, 32'h0);
        check("R8 event held", evt_status, 32'h1 << 25);
        @(negedge clk);
        evt_clr_we = 1'b1; evt_clr_data = 32'h1 << 24;
        @(negedge clk);
        evt_clr_we = 1'b0; evt_clr_data = '0;
        check("R8 other bit clear no effect", evt_status, 32'h1 << 25);
        evt_mask = 32'h1 << 25;
        @(negedge clk);
        check("R8 unmasked irq high", {31'h0, irq}, 32'h1);
        evt_mask = 32'h0;
        monitor_pop();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule